// File: doc/BRIEF.md
# Byte-Paced Command and Response Engine

This block is the device side of a byte-serial command link. A host pushes bytes into the block through a shared shift register. It then pulls response bytes back out of that register. Each byte is paced by a four-phase exchange on two active-low lines: `req_n` is driven by the host, and `ack_n` is driven by the engine. A command is one code byte. An optional in-band length byte may follow, and then the argument bytes. Once the arguments are complete, the engine hands the command to an external handler. When the handler finishes, the engine returns the response bytes, with an in-band size byte first if the response length is variable.

Argument and response lengths come from an external per-code table. The table value 8'hFF marks a variable length. The engine holds a 32-byte argument store, which the handler reads. It also holds a 32-byte response store, which the handler writes. Five states control the flow:
- IDLE waits for a code byte.
- LOAD samples the table.
- ARGS collects argument bytes.
- WAIT holds until the handler reports done.
- RESP returns the response bytes.

The transitions between states are:
- IDLE to LOAD on an accepted code byte.
- LOAD to WAIT when the table gives zero arguments, or LOAD to ARGS otherwise.
- ARGS to WAIT on the last argument byte.
- WAIT to IDLE when the response has a fixed length of zero, or WAIT to RESP otherwise.
- RESP to IDLE on the last response byte.

Top module: `hsk_cmd_engine`

## Requirements
- R1: A synchronous reset, including one in the middle of a command, leaves the engine in IDLE with `ack_n` high and `sr_irq`, `disp_go` and `sr_rdata` at zero. After reset the next code byte starts a fresh command.
- R2: The engine acts only when the pair {req_n, ack_n} differs from the pair it last recorded. With `req_n` low and `ack_n` high, `ack_n` goes low at the next clock edge and one byte is handled. With `req_n` high and `ack_n` low, `ack_n` goes high at the next edge and no byte is handled. Holding `req_n` low causes no further action.
- R3: In IDLE, a byte written by the host (`sr_host_wr`=1) is the command code. It appears on `tbl_code` and on `disp_cmd`.
- R4: When the table gives a fixed argument count N, `disp_go` pulses exactly once, one cycle after the Nth argument byte is accepted. If N is 0, it pulses right after the table is sampled. It never pulses before then.
- R5: When the table gives an argument count of 8'hFF, the first byte after the code is the argument count. A count of zero dispatches at once.
- R6: Argument byte k (k below 32) can be read at `arg_raddr`=k. Bytes beyond 32 are discarded but still count toward completion.
- R7: When the response length is a fixed zero, the engine returns to IDLE as soon as `disp_done` is seen. A following host read is then treated as a direction error.
- R8: When the response length is 8'hFF, the first read returns `disp_size`. That many stored bytes follow, and then the engine returns to IDLE.
- R9: With a fixed response length L, reads return the stored bytes 0..L-1 in order. Positions 32 and above read as zero, and `sr_rdata` changes only on an accepted read.
- R10: If `disp_known` is 0, a variable response has size 0, and a fixed response returns L zero bytes. Stored data is ignored.
- R11: A byte whose direction does not match the state is completed on the handshake but dropped. IDLE and ARGS expect host writes, and RESP expects host reads. The dropped byte leaves the state unchanged, raises no `sr_irq`, and does not change `sr_rdata`.
- R12: Every accepted byte raises `sr_irq` for exactly one cycle, and it does so while `ack_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 1 | Host transfer request, active low |
| ack_n | output | 1 | Engine acknowledge, active low |
| sr_host_wr | input | 1 | Shift-register direction: 1 = host writes, 0 = host reads |
| sr_wdata | input | 8 | Byte shifted in by the host |
| sr_rdata | output | 8 | Byte presented to the host |
| sr_irq | output | 1 | One-cycle pulse per accepted byte |
| tbl_code | output | 8 | Code presented to the length table |
| tbl_arg_len | input | 8 | Argument count for `tbl_code` (8'hFF = variable) |
| tbl_rsp_len | input | 8 | Response length for `tbl_code` (8'hFF = variable) |
| disp_go | output | 1 | One-cycle dispatch pulse |
| disp_cmd | output | 8 | Code being dispatched |
| arg_raddr | input | 5 | Handler read address into the argument store |
| arg_rdata | output | 8 | Argument byte at `arg_raddr` |
| disp_done | input | 1 | Handler finished |
| disp_known | input | 1 | Handler recognised the code |
| disp_size | input | 8 | Response size for variable-length responses |
| rsp_we | input | 1 | Handler write strobe into the response store |
| rsp_waddr | input | 5 | Handler write address |
| rsp_wdata | input | 8 | Handler write data |

## Verification
A wrong state or wrong counter shows up at the ports within one byte exchange. The failure can take three forms:
- a missing or extra `sr_irq` on that exchange;
- a `disp_go` that comes early, late or twice;
- a response byte or size byte that differs from the value the bench computes from the arguments it sent.

The bench sweeps every code through a table model with fixed, zero and variable lengths, plus overflow lengths. Any counter that drifts by one therefore corrupts the very next read. A state left behind after a command is caught because the following command's dispatch and response no longer match.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ARGS,
        ST_WAIT,
        ST_RESP
    } eng_state_t;

    localparam logic [7:0] VAR_LEN = 8'hFF;
endpackage

// File: rtl/hsk_phase.sv
module hsk_phase (
    input  logic clk,
    input  logic rst,
    input  logic req_n,
    output logic ack_n,
    output logic xfer
);
    logic [1:0] last_q;
    logic [1:0] pair;
    logic       moved;

    assign pair  = {req_n, ack_n};
    assign moved = (pair != last_q);
    assign xfer  = moved && (pair == 2'b01);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_n  <= 1'b1;
            last_q <= 2'b11;
        end else if (moved) begin
            unique case (pair)
                2'b10: begin
                    ack_n  <= 1'b1;
                    last_q <= 2'b11;
                end
                2'b01: begin
                    ack_n  <= 1'b0;
                    last_q <= 2'b00;
                end
                default: last_q <= pair;
            endcase
        end
    end
endmodule

// File: rtl/hsk_bytebuf.sv
module hsk_bytebuf #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/hsk_cmd_engine.sv
module hsk_cmd_engine
    import hsk_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    localparam int AW = $clog2(BUF_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_n,
    output logic          ack_n,
    input  logic          sr_host_wr,
    input  logic [7:0]    sr_wdata,
    output logic [7:0]    sr_rdata,
    output logic          sr_irq,
    output logic [7:0]    tbl_code,
    input  logic [7:0]    tbl_arg_len,
    input  logic [7:0]    tbl_rsp_len,
    output logic          disp_go,
    output logic [7:0]    disp_cmd,
    input  logic [AW-1:0] arg_raddr,
    output logic [7:0]    arg_rdata,
    input  logic          disp_done,
    input  logic          disp_known,
    input  logic [7:0]    disp_size,
    input  logic          rsp_we,
    input  logic [AW-1:0] rsp_waddr,
    input  logic [7:0]    rsp_wdata
);
    localparam logic [7:0] DEPTH_B = 8'(BUF_DEPTH);

    eng_state_t state_q, state_d;

    logic       xfer, wr_ok, rd_ok;
    logic [7:0] cmd_q, arg_len_q, arg_cnt_q, size_q, rsp_cnt_q, rdata_q;
    logic       arg_var_q, rsp_var_q, zero_q, irq_q, go_q;
    logic       args_last, rsp_last, arg_we;
    logic [7:0] rsp_rd, resp_byte;

    hsk_phase u_phase (
        .clk  (clk),
        .rst  (rst),
        .req_n(req_n),
        .ack_n(ack_n),
        .xfer (xfer)
    );

    assign wr_ok = xfer && sr_host_wr;
    assign rd_ok = xfer && !sr_host_wr;

    assign args_last = arg_var_q ? (sr_wdata == 8'd0)
                                 : ((arg_cnt_q + 8'd1) == arg_len_q);
    assign rsp_last  = rsp_var_q ? (size_q == 8'd0)
                                 : ((rsp_cnt_q + 8'd1) == size_q);

    assign arg_we = (state_q == ST_ARGS) && wr_ok && !arg_var_q
                    && (arg_cnt_q < DEPTH_B);

    hsk_bytebuf #(.DEPTH(BUF_DEPTH)) u_argbuf (
        .clk  (clk),
        .we   (arg_we),
        .waddr(arg_cnt_q[AW-1:0]),
        .wdata(sr_wdata),
        .raddr(arg_raddr),
        .rdata(arg_rdata)
    );

    hsk_bytebuf #(.DEPTH(BUF_DEPTH)) u_rspbuf (
        .clk  (clk),
        .we   (rsp_we),
        .waddr(rsp_waddr),
        .wdata(rsp_wdata),
        .raddr(rsp_cnt_q[AW-1:0]),
        .rdata(rsp_rd)
    );

    assign resp_byte = (zero_q || (rsp_cnt_q >= DEPTH_B)) ? 8'h00 : rsp_rd;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_ok) state_d = ST_LOAD;
            ST_LOAD: state_d = (tbl_arg_len == 8'd0) ? ST_WAIT : ST_ARGS;
            ST_ARGS: if (wr_ok && args_last) state_d = ST_WAIT;
            ST_WAIT: if (disp_done)
                         state_d = (!rsp_var_q && size_q == 8'd0) ? ST_IDLE : ST_RESP;
            ST_RESP: if (rd_ok && rsp_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= 8'd0;
            arg_len_q <= 8'd0;
            arg_cnt_q <= 8'd0;
            size_q    <= 8'd0;
            rsp_cnt_q <= 8'd0;
            rdata_q   <= 8'd0;
            arg_var_q <= 1'b0;
            rsp_var_q <= 1'b0;
            zero_q    <= 1'b0;
            irq_q     <= 1'b0;
            go_q      <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            go_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (wr_ok) begin
                    cmd_q     <= sr_wdata;
                    arg_cnt_q <= 8'd0;
                    rsp_cnt_q <= 8'd0;
                    irq_q     <= 1'b1;
                end
                ST_LOAD: begin
                    arg_len_q <= tbl_arg_len;
                    arg_var_q <= (tbl_arg_len == VAR_LEN);
                    size_q    <= tbl_rsp_len;
                    rsp_var_q <= (tbl_rsp_len == VAR_LEN);
                    go_q      <= (tbl_arg_len == 8'd0);
                end
                ST_ARGS: if (wr_ok) begin
                    irq_q <= 1'b1;
                    go_q  <= args_last;
                    if (arg_var_q) begin
                        arg_len_q <= sr_wdata;
                        arg_var_q <= 1'b0;
                    end else begin
                        arg_cnt_q <= arg_cnt_q + 8'd1;
                    end
                end
                ST_WAIT: if (disp_done) begin
                    zero_q <= !disp_known;
                    if (rsp_var_q) size_q <= disp_known ? disp_size : 8'd0;
                end
                ST_RESP: if (rd_ok) begin
                    irq_q <= 1'b1;
                    if (rsp_var_q) begin
                        rdata_q   <= size_q;
                        rsp_var_q <= 1'b0;
                    end else begin
                        rdata_q   <= resp_byte;
                        rsp_cnt_q <= rsp_cnt_q + 8'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sr_rdata = rdata_q;
    assign sr_irq   = irq_q;
    assign disp_go  = go_q;
    assign tbl_code = cmd_q;
    assign disp_cmd = cmd_q;
endmodule

// File: rtl/hsk_cmd_engine_chk.sv
module hsk_cmd_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_n,
    input logic       ack_n,
    input logic       sr_irq,
    input logic       disp_go,
    input logic [7:0] sr_rdata
);
    p_ack_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_n) |-> !$past(req_n));

    p_ack_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_n) |-> $past(req_n));

    p_irq_in_ack_r12: assert property (@(posedge clk) disable iff (rst)
        sr_irq |-> !ack_n);

    p_irq_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        sr_irq |=> !sr_irq);

    p_go_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        disp_go |=> !disp_go);

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sr_rdata) |-> sr_irq);
endmodule

bind hsk_cmd_engine hsk_cmd_engine_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .req_n   (req_n),
    .ack_n   (ack_n),
    .sr_irq  (sr_irq),
    .disp_go (disp_go),
    .sr_rdata(sr_rdata)
);

// File: tb/test_hsk_cmd_engine.sv
module test_hsk_cmd_engine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_n;
    logic       ack_n;
    logic       sr_host_wr;
    logic [7:0] sr_wdata;
    logic [7:0] sr_rdata;
    logic       sr_irq;
    logic [7:0] tbl_code;
    logic [7:0] tbl_arg_len;
    logic [7:0] tbl_rsp_len;
    logic       disp_go;
    logic [7:0] disp_cmd;
    logic [4:0] arg_raddr;
    logic [7:0] arg_rdata;
    logic       disp_done;
    logic       disp_known;
    logic [7:0] disp_size;
    logic       rsp_we;
    logic [4:0] rsp_waddr;
    logic [7:0] rsp_wdata;

    int n_vec = 0;
    int n_bad = 0;
    int go_cnt = 0;
    int done_cnt = 0;
    int cur_n = 0;
    logic [7:0] exp_cmd = 8'd0;

    // length table model: 8'hFF = variable
    function automatic logic [7:0] t_arg(input logic [7:0] c);
        if (c == 8'h41) return 8'd40;
        if (c[1:0] == 2'd3) return 8'hFF;
        return {6'd0, c[3:2]};
    endfunction

    function automatic logic [7:0] t_rsp(input logic [7:0] c);
        if (c == 8'h42) return 8'd40;
        if (c[5:4] == 2'd3) return 8'hFF;
        return {6'd0, c[5:4]};
    endfunction

    function automatic logic [7:0] argv(input logic [7:0] c, input int j);
        return 8'(int'(c) * 3 + j * 17 + 1);
    endfunction

    assign tbl_arg_len = t_arg(tbl_code);
    assign tbl_rsp_len = t_rsp(tbl_code);

    always #(CLK_PERIOD / 2) clk = ~clk;

    hsk_cmd_engine i_hsk_cmd_engine (
        .clk        (clk),
        .rst        (rst),
        .req_n      (req_n),
        .ack_n      (ack_n),
        .sr_host_wr (sr_host_wr),
        .sr_wdata   (sr_wdata),
        .sr_rdata   (sr_rdata),
        .sr_irq     (sr_irq),
        .tbl_code   (tbl_code),
        .tbl_arg_len(tbl_arg_len),
        .tbl_rsp_len(tbl_rsp_len),
        .disp_go    (disp_go),
        .disp_cmd   (disp_cmd),
        .arg_raddr  (arg_raddr),
        .arg_rdata  (arg_rdata),
        .disp_done  (disp_done),
        .disp_known (disp_known),
        .disp_size  (disp_size),
        .rsp_we     (rsp_we),
        .rsp_waddr  (rsp_waddr),
        .rsp_wdata  (rsp_wdata)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
        end
    endtask

    // one four-phase exchange; returns sr_rdata seen after the transfer edge
    task automatic hs(input bit wr, input logic [7:0] b, input bit exp_irq,
                      input int hold, input string rq, output logic [7:0] rd);
        sr_host_wr = wr;
        sr_wdata   = b;
        req_n      = 1'b0;
        @(negedge clk);
        chk(ack_n == 1'b0, "R2 ack low after request", int'(ack_n), 0);
        chk(sr_irq == exp_irq, rq, int'(sr_irq), int'(exp_irq));
        rd = sr_rdata;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(ack_n == 1'b0 && sr_irq == 1'b0, "R2 held request idle",
                int'({ack_n, sr_irq}), 0);
        end
        req_n = 1'b1;
        @(negedge clk);
        chk(ack_n == 1'b1, "R2 ack high after release", int'(ack_n), 1);
    endtask

    task automatic wait_done(input int d0);
        while (done_cnt == d0) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic run_cmd(input logic [7:0] c, input bit inject);
        logic [7:0] rd;
        logic [7:0] prev;
        logic [7:0] exp;
        int  n, nrsp, go0, d0;
        bit  var_a, var_r, known;
        string tag;
        go0   = go_cnt;
        d0    = done_cnt;
        var_a = (t_arg(c) == 8'hFF);
        var_r = (t_rsp(c) == 8'hFF);
        known = !c[7];
        n     = var_a ? (int'(c) % 5) : int'(t_arg(c));
        exp_cmd = c;
        cur_n   = n;
        hs(1'b1, c, 1'b1, 0, "R12 irq on code byte", rd);
        if (inject) hs(1'b0, 8'h00, 1'b0, 0, "R11 read dropped while collecting", rd);
        if (var_a) hs(1'b1, 8'(n), 1'b1, 0, "R5 irq on length byte", rd);
        for (int j = 0; j < n; j++) begin
            if (j == n - 1) begin
                #1;
                chk(go_cnt == go0, var_a ? "R5 no early dispatch" : "R4 no early dispatch",
                    go_cnt, go0);
            end
            hs(1'b1, argv(c, j), 1'b1, 0, "R12 irq on argument", rd);
        end
        wait_done(d0);
        chk(go_cnt == go0 + 1, var_a ? "R5 single dispatch" : "R4 single dispatch",
            go_cnt, go0 + 1);
        nrsp = var_r ? (known ? n + 1 : 0) : int'(t_rsp(c));
        if (inject && (var_r || nrsp != 0)) begin
            prev = sr_rdata;
            hs(1'b1, 8'h5A, 1'b0, 0, "R11 write dropped while responding", rd);
            chk(rd == prev, "R11 sr_rdata kept", int'(rd), int'(prev));
        end
        if (var_r) begin
            hs(1'b0, 8'h00, 1'b1, 0, "R12 irq on size byte", rd);
            chk(rd == 8'(nrsp), known ? "R8 size byte" : "R10 unknown size zero",
                int'(rd), nrsp);
        end
        for (int i = 0; i < nrsp; i++) begin
            hs(1'b0, 8'h00, 1'b1, 0, "R12 irq on response", rd);
            if (!known) begin
                exp = 8'h00; tag = "R10 unknown zero fill";
            end else if (i >= 32) begin
                exp = 8'h00; tag = "R9 beyond store reads zero";
            end else if (i < n) begin
                exp = 8'(argv(c, i) + c + 8'(i)); tag = "R6 stored argument";
            end else begin
                exp = 8'(8'hA5 + c + 8'(i)); tag = "R9 response order";
            end
            chk(rd == exp, tag, int'(rd), int'(exp));
        end
        if (!var_r && nrsp == 0 && !inject)
            hs(1'b0, 8'h00, 1'b0, 0, "R7 back in idle", rd);
    endtask

    // handler model
    logic [7:0] d_code;
    logic [7:0] d_got [32];
    int d_nst, d_wcnt;
    initial begin
        arg_raddr  = 5'd0;
        rsp_we     = 1'b0;
        rsp_waddr  = 5'd0;
        rsp_wdata  = 8'd0;
        disp_done  = 1'b0;
        disp_known = 1'b0;
        disp_size  = 8'd0;
        forever begin
            @(negedge clk);
            if (disp_go) begin
                d_code = disp_cmd;
                go_cnt++;
                chk(d_code == exp_cmd, "R3 dispatched code", int'(d_code), int'(exp_cmd));
                d_nst = (cur_n < 32) ? cur_n : 32;
                for (int i = 0; i < d_nst; i++) begin
                    arg_raddr = 5'(i);
                    #1;
                    d_got[i] = arg_rdata;
                end
                if (t_rsp(d_code) == 8'hFF) d_wcnt = cur_n + 1;
                else d_wcnt = (t_rsp(d_code) > 8'd32) ? 32 : int'(t_rsp(d_code));
                for (int i = 0; i < d_wcnt; i++) begin
                    rsp_we    = 1'b1;
                    rsp_waddr = 5'(i);
                    rsp_wdata = d_code[7] ? 8'hEE
                              : 8'(((i < d_nst) ? d_got[i] : 8'hA5) + d_code + 8'(i));
                    @(negedge clk);
                end
                rsp_we     = 1'b0;
                disp_known = !d_code[7];
                disp_size  = 8'(cur_n + 1);
                disp_done  = 1'b1;
                @(negedge clk);
                disp_done  = 1'b0;
                done_cnt++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int d0;
        rst        = 1'b1;
        req_n      = 1'b1;
        sr_host_wr = 1'b1;
        sr_wdata   = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ack_n == 1'b1, "R1 ack high after reset", int'(ack_n), 1);
        chk(sr_irq == 1'b0, "R1 irq low after reset", int'(sr_irq), 0);
        chk(disp_go == 1'b0, "R1 no dispatch after reset", int'(disp_go), 0);
        chk(sr_rdata == 8'd0, "R1 rdata zero after reset", int'(sr_rdata), 0);

        // read direction in IDLE is dropped
        hs(1'b0, 8'h33, 1'b0, 0, "R11 read dropped in idle", rd);
        chk(rd == 8'd0, "R11 rdata unchanged in idle", int'(rd), 0);

        // request held low past the acknowledge
        exp_cmd = 8'h00;
        cur_n   = 0;
        d0      = done_cnt;
        hs(1'b1, 8'h00, 1'b1, 3, "R12 irq on held code byte", rd);
        wait_done(d0);
        chk(done_cnt == d0 + 1, "R4 zero-argument dispatch", done_cnt, d0 + 1);

        // sweep every code through the table model
        for (int c = 0; c < 256; c++) run_cmd(8'(c), 1'b0);

        // direction errors inside commands
        run_cmd(8'h15, 1'b1);
        run_cmd(8'h97, 1'b1);
        run_cmd(8'h3B, 1'b1);

        // reset in the middle of a long command
        hs(1'b1, 8'h41, 1'b1, 0, "R12 irq before reset", rd);
        for (int j = 0; j < 3; j++) hs(1'b1, argv(8'h41, j), 1'b1, 0, "R12 irq before reset", rd);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ack_n == 1'b1 && sr_irq == 1'b0, "R1 idle after mid-command reset",
            int'({ack_n, sr_irq}), 2);
        run_cmd(8'h15, 1'b0);
        run_cmd(8'h3B, 1'b0);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule